// File: doc/BRIEF.md
# CAN Arbitration Field Transmitter

This block puts the opening of a standard-format CAN frame onto a shared wired-AND bus. That opening is one dominant start bit, then the 11-bit identifier with its most significant bit first, then the remote-request flag. The block sends one bit per bit time. An external bit timing unit supplies two single-cycle strobes for each bit: a transmit-point strobe, which tells the block when to change its output, and a sample-point strobe, which tells it when the sampled bus level is valid. The block compares the level it drove with the level it sampled. If it sent recessive and a competing node forced dominant, the block has lost arbitration. It then stops competing and only listens.

A frame request enters through a valid/ready handshake. Ready is high only while the block is idle, so a request made during a frame is held off until the frame ends. The sender keeps valid, identifier and flag steady until ready is high. Before the block accepts an identifier it checks that identifier. If the seven most significant identifier bits are all recessive, the request is consumed and refused with a reject pulse, and the bus is never touched. When the remote-request bit is sampled without a loss, the block raises a one-cycle arbitration-won pulse and returns to idle. A surrounding frame engine then continues with the rest of the frame.

Top module: `can_arb_tx`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a frame is in progress, `req_ready` stays low and requests are not taken.
- R2: An identifier is illegal when its bits 10 down to 4 are all 1. Such a request is consumed and answered with a one-cycle `req_reject` pulse on the next cycle. `busy` stays low, `tx_bit` stays 1, and no strobe drives anything afterwards.
- R3: Logic 0 on `tx_bit` and on `bus_rx` means dominant, and logic 1 means recessive. Whenever `busy` is low, `tx_bit` is 1.
- R4: The bit index runs from 0 to 12. Index 0 is the dominant start bit, indexes 1 to 11 carry identifier bits 10 down to 0, and index 12 carries the remote-request flag. Each bit appears on `tx_bit` at the clock edge where `tx_pt` is high. After that, a `smp_pt` strobe completes the bit. A `smp_pt` that arrives while the block is waiting for `tx_pt` is ignored, and so is a `tx_pt` that arrives while it is waiting for `smp_pt`.
- R5: If the block drives recessive and samples dominant at an index from 1 to 12, it pulses `arb_lost` for one cycle and sets `lost_idx` to that index. From then on it drives recessive until index 12 has been sampled. It then returns to idle without pulsing `arb_won`.
- R6: If index 12 is sampled and arbitration was not lost, `arb_won` pulses for one cycle, and `busy` goes low in that same cycle.
- R7: If the block drives dominant and samples recessive at any index, including the start bit, it pulses `bit_err` for one cycle, abandons the frame and returns to idle with `tx_bit` at 1.
- R8: At most one of `arb_lost`, `arb_won`, `bit_err` and `req_reject` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Block is idle and can take a request |
| req_id | input | ID_W | Identifier to send |
| req_rtr | input | 1 | Remote-request flag to send |
| tx_pt | input | 1 | Transmit-point strobe |
| smp_pt | input | 1 | Sample-point strobe |
| bus_rx | input | 1 | Sampled bus level (0 = dominant) |
| tx_bit | output | 1 | Transmitted level (0 = dominant) |
| busy | output | 1 | Frame opening in progress |
| arb_lost | output | 1 | One-cycle arbitration-lost pulse |
| lost_idx | output | IDX_W | Bit index where arbitration was lost |
| arb_won | output | 1 | One-cycle arbitration-won pulse |
| bit_err | output | 1 | One-cycle bit-error pulse |
| req_reject | output | 1 | One-cycle illegal-identifier pulse |

## Verification
On every cycle, the assertions check several rules. The bus is left recessive while idle. The result pulses never overlap. A loss is reported only on a recessive bit and at an index from 1 to 12. A win, a bit error and a reject each coincide with the idle state, and ready tracks idle. Only the bench scenarios can show the following. The transmitted bit sequence really follows the identifier. The reported loss index matches the first bit where a competitor undercut the block. The block keeps quiet for the rest of the field after a loss. A strobe that arrives out of turn changes nothing.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRIVE  = 2'd1,
    ST_SAMPLE = 2'd2
  } arb_st_e;

  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;
endpackage

// File: rtl/can_arb_legal.sv
module can_arb_legal #(
  parameter int ID_W    = 11,
  parameter int GUARD_W = 7
) (
  input  logic [ID_W-1:0] id,
  output logic            legal
);
  logic [GUARD_W-1:0] guard;

  for (genvar gi = 0; gi < GUARD_W; gi++) begin : g_guard
    assign guard[gi] = id[ID_W-1-gi];
  end

  // all-recessive top bits form a forbidden identifier
  assign legal = ~(&guard);
endmodule

// File: rtl/can_arb_shifter.sv
module can_arb_shifter #(
  parameter int FRAME_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_bits,
  input  logic               step,
  output logic               cur_bit
);
  logic [FRAME_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '1;
    end else if (load) begin
      sreg <= load_bits;
    end else if (step) begin
      sreg <= {sreg[FRAME_W-2:0], 1'b1};
    end
  end

  assign cur_bit = sreg[FRAME_W-1];
endmodule

// File: rtl/can_arb_idx.sv
module can_arb_idx #(
  parameter int FRAME_W = 13,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (load) begin
      idx <= '0;
    end else if (step) begin
      idx <= idx + 1'b1;
    end
  end

  assign last = (idx == LAST_IDX);
endmodule

// File: rtl/can_arb_tx.sv
module can_arb_tx
  import can_arb_pkg::*;
#(
  parameter int ID_W    = 11,
  parameter int GUARD_W = 7,
  localparam int FRAME_W = ID_W + 2,
  localparam int IDX_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  req_id,
  input  logic             req_rtr,
  input  logic             tx_pt,
  input  logic             smp_pt,
  input  logic             bus_rx,
  output logic             tx_bit,
  output logic             busy,
  output logic             arb_lost,
  output logic [IDX_W-1:0] lost_idx,
  output logic             arb_won,
  output logic             bit_err,
  output logic             req_reject
);
  arb_st_e          st;
  logic             lost_q;
  logic             tx_q;
  logic             id_legal;
  logic             take;
  logic             load;
  logic             step;
  logic             cur_bit;
  logic [IDX_W-1:0] idx;
  logic             last;
  logic             smp_now;
  logic             err_now;
  logic             lose_now;

  can_arb_legal #(.ID_W(ID_W), .GUARD_W(GUARD_W)) u_legal (
    .id    (req_id),
    .legal (id_legal)
  );

  assign take    = req_valid && (st == ST_IDLE);
  assign load    = take && id_legal;
  assign smp_now = (st == ST_SAMPLE) && smp_pt;
  assign err_now = smp_now && (tx_q == LVL_DOM) && (bus_rx == LVL_REC);
  assign lose_now = smp_now && !lost_q && (idx != '0) &&
                    (tx_q == LVL_REC) && (bus_rx == LVL_DOM);
  assign step    = smp_now && !err_now && !last;

  can_arb_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_bits ({LVL_DOM, req_id, req_rtr}),
    .step      (step),
    .cur_bit   (cur_bit)
  );

  can_arb_idx #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .idx   (idx),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      lost_q     <= 1'b0;
      tx_q       <= LVL_REC;
      arb_lost   <= 1'b0;
      lost_idx   <= '0;
      arb_won    <= 1'b0;
      bit_err    <= 1'b0;
      req_reject <= 1'b0;
    end else begin
      arb_lost   <= 1'b0;
      arb_won    <= 1'b0;
      bit_err    <= 1'b0;
      req_reject <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (take) begin
            if (id_legal) st <= ST_DRIVE;
            else          req_reject <= 1'b1;
          end
        end
        ST_DRIVE: begin
          if (tx_pt) begin
            tx_q <= lost_q ? LVL_REC : cur_bit;
            st   <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          if (smp_pt) begin
            if (err_now) begin
              bit_err <= 1'b1;
              tx_q    <= LVL_REC;
              lost_q  <= 1'b0;
              st      <= ST_IDLE;
            end else begin
              if (lose_now) begin
                arb_lost <= 1'b1;
                lost_idx <= idx;
              end
              if (last) begin
                arb_won <= !lost_q && !lose_now;
                lost_q  <= 1'b0;
                tx_q    <= LVL_REC;
                st      <= ST_IDLE;
              end else begin
                lost_q <= lost_q || lose_now;
                st     <= ST_DRIVE;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tx_bit    = tx_q;
  assign busy      = (st != ST_IDLE);
  assign req_ready = (st == ST_IDLE);
endmodule

// File: rtl/can_arb_tx_chk.sv
module can_arb_tx_chk #(
  parameter int FRAME_W = 13,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             tx_bit,
  input logic             busy,
  input logic             arb_lost,
  input logic [IDX_W-1:0] lost_idx,
  input logic             arb_won,
  input logic             bit_err,
  input logic             req_reject
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(FRAME_W - 1);

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !busy);

  assert_reject_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (!busy && !$past(busy) && tx_bit));

  assert_idle_recessive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_bit);

  assert_lost_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (tx_bit && (lost_idx != '0) && (lost_idx <= MAX_IDX)));

  assert_won_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_won |-> (!busy && $past(busy)));

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> (!busy && tx_bit && $past(busy)));

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_lost, arb_won, bit_err, req_reject}));
endmodule

bind can_arb_tx can_arb_tx_chk #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .tx_bit     (tx_bit),
  .busy       (busy),
  .arb_lost   (arb_lost),
  .lost_idx   (lost_idx),
  .arb_won    (arb_won),
  .bit_err    (bit_err),
  .req_reject (req_reject)
);

// File: tb/sim_can_arb_tx.sv
module sim_can_arb_tx;
  localparam int ID_W = 11;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [ID_W-1:0]  req_id = '0;
  logic             req_rtr = 1'b0;
  logic             tx_pt = 1'b0;
  logic             smp_pt = 1'b0;
  logic             bus_rx = 1'b1;
  logic             tx_bit;
  logic             busy;
  logic             arb_lost;
  logic [IDX_W-1:0] lost_idx;
  logic             arb_won;
  logic             bit_err;
  logic             req_reject;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_arb_tx u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_rtr(req_rtr), .tx_pt(tx_pt), .smp_pt(smp_pt),
    .bus_rx(bus_rx), .tx_bit(tx_bit), .busy(busy), .arb_lost(arb_lost),
    .lost_idx(lost_idx), .arb_won(arb_won), .bit_err(bit_err),
    .req_reject(req_reject)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic strobe_tx();
    @(negedge clk) tx_pt = 1'b1;
    @(negedge clk) tx_pt = 1'b0;
  endtask

  task automatic strobe_smp(input logic lvl);
    @(negedge clk) begin bus_rx = lvl; smp_pt = 1'b1; end
    @(negedge clk) smp_pt = 1'b0;
  endtask

  task automatic request(input logic [ID_W-1:0] id, input logic rtr);
    @(negedge clk) begin req_valid = 1'b1; req_id = id; req_rtr = rtr; end
    chk(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);
    @(negedge clk) req_valid = 1'b0;
  endtask

  // one frame against a competitor; expected results computed from the bit order
  task automatic run_pair(input logic [ID_W-1:0] oid, input logic ortr,
                          input logic [ID_W-1:0] cid, input logic crtr);
    logic [ID_W:0] ov;
    logic [ID_W:0] cv;
    logic lost_e;
    logic ob, cb, exp_tx, bus;
    int loss_at;
    ov = {oid, ortr};
    cv = {cid, crtr};
    lost_e = 1'b0;
    loss_at = 0;
    request(oid, ortr);
    chk(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
    for (int k = 0; k <= ID_W + 1; k++) begin
      ob = (k == 0) ? 1'b0 : ov[ID_W + 1 - k];
      cb = (k == 0) ? 1'b0 : cv[ID_W + 1 - k];
      exp_tx = lost_e ? 1'b1 : ob;
      strobe_tx();
      chk(tx_bit == exp_tx, lost_e ? "R5 recessive after loss" : "R4 bit order",
          int'(tx_bit), int'(exp_tx));
      bus = exp_tx & cb;
      strobe_smp(bus);
      if (!lost_e && k > 0 && exp_tx && !cb) begin
        lost_e = 1'b1;
        loss_at = k;
        chk(arb_lost == 1'b1, "R5 loss pulse", int'(arb_lost), 1);
        chk(int'(lost_idx) == k, "R5 loss index", int'(lost_idx), k);
      end else begin
        chk(arb_lost == 1'b0, "R5 no spurious loss", int'(arb_lost), 0);
      end
      if (k < ID_W + 1) begin
        chk(busy == 1'b1 && !arb_won, "R6 still busy mid-field", int'(busy), 1);
      end
    end
    chk(arb_won == !lost_e, "R6 won pulse", int'(arb_won), int'(!lost_e));
    chk(busy == 1'b0 && tx_bit == 1'b1, "R3 idle after field", int'(busy), 0);
    @(negedge clk);
    chk(arb_won == 1'b0, "R6 won lasts one cycle", int'(arb_won), 0);
    if (loss_at < 0) $display("unreachable");
  endtask

  initial begin
    logic [ID_W-1:0] oid;
    logic [ID_W-1:0] cid;
    logic orr, crr;
    repeat (3) @(negedge clk);
    chk(tx_bit == 1'b1 && busy == 1'b0, "R3 reset idle recessive", int'(tx_bit), 1);
    chk(arb_lost == 0 && arb_won == 0 && bit_err == 0 && req_reject == 0,
        "R8 reset no pulses", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // R2: every identifier with bits 10..4 all recessive is refused
    for (int lo = 0; lo < 16; lo++) begin
      @(negedge clk) begin req_valid = 1'b1; req_id = {7'h7F, lo[3:0]}; req_rtr = lo[0]; end
      @(negedge clk) req_valid = 1'b0;
      chk(req_reject == 1'b1, "R2 reject pulse", int'(req_reject), 1);
      chk(busy == 1'b0 && tx_bit == 1'b1, "R2 stays idle", int'(busy), 0);
      strobe_tx();
      chk(tx_bit == 1'b1 && req_reject == 1'b0, "R2 nothing driven", int'(tx_bit), 1);
    end

    // R2 boundary: one dominant bit among the top seven is legal
    run_pair(11'h7EF, 1'b0, 11'h7FF, 1'b1);

    // R4: out-of-turn sample strobe ignored, then out-of-turn tx strobe ignored
    request(11'h123, 1'b0);
    strobe_smp(1'b0);
    chk(busy == 1'b1 && arb_lost == 0 && bit_err == 0, "R4 early sample ignored", int'(busy), 1);
    strobe_tx();
    chk(tx_bit == 1'b0, "R4 start bit dominant", int'(tx_bit), 0);
    strobe_tx();
    chk(tx_bit == 1'b0, "R4 extra tx strobe ignored", int'(tx_bit), 0);
    // R7: recessive sampled on the dominant start bit
    strobe_smp(1'b1);
    chk(bit_err == 1'b1, "R7 bit error pulse", int'(bit_err), 1);
    chk(busy == 1'b0 && tx_bit == 1'b1, "R7 abort to idle", int'(busy), 0);
    @(negedge clk);
    chk(bit_err == 1'b0, "R7 single pulse", int'(bit_err), 0);

    // R1: request held while busy is not taken
    request(11'h055, 1'b1);
    @(negedge clk) begin req_valid = 1'b1; req_id = 11'h001; end
    chk(req_ready == 1'b0, "R1 not ready while busy", int'(req_ready), 0);
    @(negedge clk) req_valid = 1'b0;
    strobe_tx();
    strobe_smp(1'b0);
    strobe_tx();
    chk(tx_bit == 1'b0, "R1 frame unaffected (ID.10 of 0x055)", int'(tx_bit), 0);
    // R7 mid-field: dominant ID bit seen recessive
    strobe_smp(1'b1);
    chk(bit_err == 1'b1 && busy == 1'b0, "R7 mid-field error", int'(bit_err), 1);

    // sweep: single-bit competitor differences at every position, both rtr values
    for (int i = 0; i < 20; i++) begin
      for (int j = 0; j < 12; j++) begin
        oid = ID_W'((i * 389 + 5) & 11'h7FF);
        if (oid[10:4] == 7'h7F) oid[10] = 1'b0;
        orr = i[0];
        if (j < 11) begin
          cid = oid ^ ID_W'(1 << j);
          crr = orr;
        end else begin
          cid = oid;
          crr = ~orr;
        end
        run_pair(oid, orr, cid, crr);
      end
    end

    // silent competitor and identical competitor both yield a win
    run_pair(11'h000, 1'b0, 11'h7FF, 1'b1);
    run_pair(11'h3A5, 1'b1, 11'h3A5, 1'b1);

    finish_run();
  end
endmodule